// File: doc/BRIEF.md
# ADC Serial Port Responder

A synthesizable device-side model of a 14-bit multi-channel sampling converter's serial port. It is meant for test benches and emulation platforms that need a converter to talk to. It runs on a fast system clock and oversamples the conversion-start, serial-clock and serial-data-in lines. It answers on a serial data line that has a separate output enable, so the surrounding logic can build the tri-state pad.

A rising conversion-start line begins a conversion, and a fixed timer marks its end. At every end of conversion three things happen. A fully shifted configuration word is committed, if it asks to be applied. The channel for the next conversion is chosen, either fixed or by a wrapping sequencer. The output shift register is reloaded with the new result, optionally followed by the active configuration. The data line is enabled when the start line falls. It is released after an exact number of falling serial-clock edges.

Results are synthetic, so a bench can predict them. Each one carries its channel number and a conversion index. The first results after reset carry a fixed marker, because a real part gives undefined data there.

Top module: `adc_serial_responder`

## Requirements
- R1: A rising edge on cnv_i while idle starts a conversion that ends exactly CONV_CYCLES clocks later. A rising edge on cnv_i while a conversion runs is ignored and does not restart or extend it.
- R2: Each rising sck_i edge shifts din_i, MSB first, into a 14-bit input word. Bits beyond the 14th are ignored. At end of conversion the word is committed only if all 14 bits arrived since the previous end of conversion and bit 13 (apply) is 1. A partial word is dropped and the active configuration is kept.
- R3: At end of conversion the output register is reloaded with the new result, unread bits are lost, and sdo_oe_o is low until the next falling cnv_i edge.
- R4: A falling cnv_i edge after an end of conversion sets sdo_oe_o, with the result MSB on sdo_o. Each falling sck_i edge then presents the next bit.
- R5: With configuration bit 0 (readback) clear, sdo_oe_o drops after exactly 14 falling sck_i edges.
- R6: With readback set, the 14 result bits are followed by the 14 bits of the active configuration, MSB first, and sdo_oe_o drops after exactly 28 falling sck_i edges.
- R7: With configuration bit 3 (sequencer) set, successive conversions use channels 0, 1, … up to the channel in bits [9:7], then wrap to 0. Committing a configuration with the sequencer set restarts at channel 0.
- R8: With the sequencer clear, every conversion after the commit uses the channel in bits [9:7].
- R9: The first three results after reset are the marker 14'h2AAA.
- R10: Result number k (counted from 0 after reset, k ≥ 3) equals {channel[2:0], k mod 2048}.
- R11: After reset sdo_oe_o and sdo_o are low and the configuration is all zero (sequencer off, channel 0, readback off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Conversion start; falling edge enables the data line |
| sck_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial configuration data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
The hardest case to reach is the one-conversion delay between writing a word and its effect. A word shifted in during one read only lands at the next end of conversion, and a sequencer commit then restarts the channel walk from zero. The stimulus therefore runs every sequencer bound from 0 to 7 for several wraps. It also runs every fixed channel, and predicts each result and readback through an arithmetic model of that pipeline. A start pulse injected mid-conversion, a ten-bit partial write, a short read and an over-long write reach the discard and ignore paths.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;
  localparam int CH_W      = 3;
  localparam int CH_LSB    = 7;
  localparam int SEQ_BIT   = 3;
  localparam int RB_BIT    = 0;
  localparam int APPLY_BIT = 13;

  typedef logic [CH_W-1:0] chan_t;

  function automatic chan_t seq_step(chan_t cur, chan_t last);
    return (cur >= last) ? chan_t'(0) : chan_t'(cur + chan_t'(1));
  endfunction
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic eoc_o
);
  localparam int CW = $clog2(CONV_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign eoc_o = busy_q && (cnt_q == CW'(CONV_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (eoc_o) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !eoc_o |=> busy_q); // R1
  AST_EOC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !busy_q); // R1
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !eoc_o |=> cnt_q == $past(cnt_q) + CW'(1)); // R1
endmodule

// File: rtl/adc_cfg_port.sv
module adc_cfg_port
  import adc_resp_pkg::*;
#(
  parameter int CFG_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_rise_i,
  input  logic             din_i,
  input  logic             eoc_i,
  output logic [CFG_W-1:0] cfg_next_o,
  output logic             commit_o,
  output logic             act_seq_o,
  output chan_t            act_ch_o
);
  localparam int NW = $clog2(CFG_W + 1);

  logic [CFG_W-1:0] sh_q, cfg_q;
  logic [NW-1:0]    cnt_q;
  logic             full;

  assign full       = (cnt_q == NW'(CFG_W));
  assign commit_o   = eoc_i && full && sh_q[APPLY_BIT];
  assign cfg_next_o = (full && sh_q[APPLY_BIT]) ? sh_q : cfg_q;
  assign act_seq_o  = cfg_q[SEQ_BIT];
  assign act_ch_o   = cfg_q[CH_LSB +: CH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cfg_q <= '0;
      cnt_q <= '0;
    end else if (eoc_i) begin
      cnt_q <= '0;
      if (commit_o) cfg_q <= sh_q;
    end else if (sck_rise_i && !full) begin
      sh_q  <= {sh_q[CFG_W-2:0], din_i};
      cnt_q <= cnt_q + NW'(1);
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_i |=> $stable(cfg_q)); // R2
  AST_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NW'(CFG_W)); // R2
  AST_FULL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && !eoc_i |=> $stable(sh_q)); // R2
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_resp_pkg::*;
#(
  parameter int              DATA_W  = 14,
  parameter int              UNDEF_N = 3,
  parameter logic [DATA_W-1:0] MARKER = 14'h2AAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eoc_i,
  input  logic              commit_i,
  input  logic              act_seq_i,
  input  chan_t             act_ch_i,
  input  logic              nxt_seq_i,
  input  chan_t             nxt_ch_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int SAMP_W = DATA_W - CH_W;
  localparam int UW     = $clog2(UNDEF_N + 1);

  chan_t             chan_q, chan_d;
  logic [SAMP_W-1:0] idx_q;
  logic [UW-1:0]     undef_q;

  always_comb begin
    if (commit_i)       chan_d = nxt_seq_i ? chan_t'(0) : nxt_ch_i;
    else if (act_seq_i) chan_d = seq_step(chan_q, act_ch_i);
    else                chan_d = act_ch_i;
  end

  assign result_o = (undef_q != '0) ? MARKER : {chan_q, idx_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q  <= '0;
      idx_q   <= '0;
      undef_q <= UW'(UNDEF_N);
    end else if (eoc_i) begin
      chan_q <= chan_d;
      idx_q  <= idx_q + SAMP_W'(1);
      if (undef_q != '0) undef_q <= undef_q - UW'(1);
    end
  end

  AST_SEQ_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_seq_i |-> chan_q <= act_ch_i); // R7
  AST_UNDEF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_i |=> $stable(undef_q) && $stable(idx_q)); // R9
  AST_CHAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_i |=> $stable(chan_q)); // R8
endmodule

// File: rtl/adc_sdo_shift.sv
module adc_sdo_shift
  import adc_resp_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CFG_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [CFG_W-1:0]  cfg_next_i,
  input  logic              cnv_fall_i,
  input  logic              sck_fall_i,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int TOT_W = DATA_W + CFG_W;
  localparam int CW    = $clog2(TOT_W + 1);

  logic [TOT_W-1:0] sh_q;
  logic [CW-1:0]    cnt_q, lim_q;
  logic             armed_q, oe_q;

  assign oe_o  = oe_q;
  assign sdo_o = oe_q & sh_q[TOT_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      lim_q   <= CW'(DATA_W);
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (eoc_i) begin
      sh_q    <= {result_i, cfg_next_i};
      lim_q   <= cfg_next_i[RB_BIT] ? CW'(TOT_W) : CW'(DATA_W);
      cnt_q   <= '0;
      armed_q <= 1'b1;
      oe_q    <= 1'b0;
    end else if (armed_q && cnv_fall_i) begin
      armed_q <= 1'b0;
      oe_q    <= 1'b1;
    end else if (oe_q && sck_fall_i) begin
      sh_q  <= {sh_q[TOT_W-2:0], 1'b0};
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q + CW'(1) == lim_q) oe_q <= 1'b0;
    end
  end

  AST_EOC_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> !oe_q); // R3
  AST_OE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(cnv_fall_i)); // R4
  AST_EDGE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> cnt_q < lim_q); // R5
  AST_LIM_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q == CW'(DATA_W) || lim_q == CW'(TOT_W)); // R6
endmodule

// File: rtl/adc_serial_responder.sv
module adc_serial_responder
  import adc_resp_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CFG_W       = 14,
  parameter int CONV_CYCLES = 20,
  parameter int UNDEF_N     = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnv_i,
  input  logic sck_i,
  input  logic din_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic cnv_q, sck_q;
  logic cnv_rise, cnv_fall, sck_rise, sck_fall;
  logic eoc, commit, act_seq;
  chan_t act_ch;
  logic [CFG_W-1:0]  cfg_next;
  logic [DATA_W-1:0] result;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cnv_q <= cnv_i;
      sck_q <= sck_i;
    end
  end

  assign cnv_rise = cnv_i & ~cnv_q;
  assign cnv_fall = ~cnv_i & cnv_q;
  assign sck_rise = sck_i & ~sck_q;
  assign sck_fall = ~sck_i & sck_q;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(cnv_rise), .eoc_o(eoc)
  );

  adc_cfg_port #(.CFG_W(CFG_W)) u_cfg (
    .clk_i, .rst_ni, .sck_rise_i(sck_rise), .din_i, .eoc_i(eoc),
    .cfg_next_o(cfg_next), .commit_o(commit),
    .act_seq_o(act_seq), .act_ch_o(act_ch)
  );

  adc_chan_seq #(.DATA_W(DATA_W), .UNDEF_N(UNDEF_N)) u_seq (
    .clk_i, .rst_ni, .eoc_i(eoc), .commit_i(commit),
    .act_seq_i(act_seq), .act_ch_i(act_ch),
    .nxt_seq_i(cfg_next[SEQ_BIT]), .nxt_ch_i(cfg_next[CH_LSB +: CH_W]),
    .result_o(result)
  );

  adc_sdo_shift #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_sdo (
    .clk_i, .rst_ni, .eoc_i(eoc), .result_i(result), .cfg_next_i(cfg_next),
    .cnv_fall_i(cnv_fall), .sck_fall_i(sck_fall),
    .sdo_o, .oe_o(sdo_oe_o)
  );

  AST_SDO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o); // R11
endmodule

// File: tb/adc_serial_responder_bench.sv
module adc_serial_responder_bench;
  localparam int C = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cnv_i = 1'b0, sck_i = 1'b0, din_i = 1'b0;
  logic sdo_o, sdo_oe_o;

  int total = 0, bad = 0;
  int m_idx = 0;
  logic [2:0]  m_chan = '0;
  logic [13:0] m_cfg = '0;
  logic [13:0] m_pend = '0;
  logic        m_pend_ok = 1'b0;
  logic [13:0] e_res;
  logic [13:0] e_cfg;

  always #4 clk_i = ~clk_i;

  adc_serial_responder #(.CONV_CYCLES(C)) u_adc_serial_responder (
    .clk_i, .rst_ni, .cnv_i, .sck_i, .din_i, .sdo_o, .sdo_oe_o
  );

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mkcfg(logic seq, logic [2:0] ch, logic rb);
    return 14'h2000 | (14'(ch) << 7) | (14'(seq) << 3) | 14'(rb);
  endfunction

  task automatic model_eoc();
    e_res = (m_idx < 3) ? 14'h2AAA : {m_chan, 11'(m_idx)};
    m_idx++;
    if (m_pend_ok) begin
      m_cfg  = m_pend;
      m_chan = m_cfg[3] ? 3'd0 : m_cfg[9:7];
    end else if (m_cfg[3]) begin
      m_chan = (m_chan >= m_cfg[9:7]) ? 3'd0 : m_chan + 3'd1;
    end else begin
      m_chan = m_cfg[9:7];
    end
    m_pend_ok = 1'b0;
    e_cfg = m_cfg;
  endtask

  // cnv already low and output enabled; n serial clocks
  task automatic do_read(logic [13:0] wr, bit wen, int n, string rtag);
    logic [13:0] a_res = '0, a_cfg = '0;
    int lim = e_cfg[0] ? 28 : 14;
    int k;
    for (int i = 0; i < n; i++) begin
      din_i = wen ? ((i < 14) ? wr[13-i] : 1'b1) : 1'b0;
      if (i < 14) a_res[13-i] = sdo_o;
      else if (i < 28) a_cfg[27-i] = sdo_o;
      sck_i = 1'b1; tick();
      sck_i = 1'b0; tick();
    end
    din_i = 1'b0;
    k = (n < 14) ? n : 14;
    chk(rtag, int'(a_res >> (14 - k)), int'(e_res >> (14 - k)));
    if (e_cfg[0] && n >= 28) chk("R6 readback", a_cfg, e_cfg);
    chk(lim == 14 ? "R5 release" : "R6 release", sdo_oe_o, (n < lim) ? 1 : 0);
    if (wen && n >= 14 && wr[13]) begin
      m_pend = wr; m_pend_ok = 1'b1;
    end
  endtask

  function automatic string res_tag();
    if (m_idx <= 3) return "R9 marker";
    return m_cfg[3] ? "R7 R10 result" : "R8 R10 result";
  endfunction

  task automatic do_conv(logic [13:0] wr, bit wen, int n);
    string t;
    cnv_i = 1'b1; tick();
    repeat (C) tick();
    chk("R3 hiz before cnv fall", sdo_oe_o, 0);
    t = res_tag();
    model_eoc();
    cnv_i = 1'b0; tick();
    chk("R4 enable", sdo_oe_o, 1);
    do_read(wr, wen, n, t);
  endtask

  initial begin
    repeat (3) tick();
    chk("R11 oe reset", sdo_oe_o, 0);
    chk("R11 sdo reset", sdo_o, 0);
    rst_ni = 1'b1; tick();
    chk("R11 oe after reset", sdo_oe_o, 0);

    // marker results, then write readback + fixed channel 5
    do_conv('0, 0, 14);
    do_conv('0, 0, 14);
    do_conv(mkcfg(0, 3'd5, 1), 1, 14);
    do_conv('0, 0, 28);
    do_conv('0, 0, 28);

    // partial write of a sequencer word is dropped (R2)
    do_conv(mkcfg(1, 3'd7, 1), 1, 10);
    do_conv('0, 0, 28);
    chk("R2 partial dropped", m_cfg, mkcfg(0, 3'd5, 1));

    // word without apply bit is ignored (R2)
    do_conv(mkcfg(1, 3'd2, 1) & 14'h1FFF, 1, 28);
    do_conv('0, 0, 28);

    // sequencer sweep over every upper bound (R7)
    for (int l = 0; l < 8; l++) begin
      do_conv(mkcfg(1, 3'(l), 1), 1, 28);
      for (int r = 0; r < l + 4; r++) do_conv('0, 0, 28);
    end

    // fixed channel sweep, readback off (R8, R5)
    for (int ch = 0; ch < 8; ch++) begin
      do_conv(mkcfg(0, 3'(ch), 0), 1, 14);
      do_conv('0, 0, 14);
      do_conv('0, 0, 14);
    end

    // over-long write: trailing ones ignored (R2)
    do_conv(mkcfg(1, 3'd3, 1), 1, 14);
    do_conv(mkcfg(0, 3'd6, 1), 1, 28);
    do_conv('0, 0, 28);
    chk("R2 extra bits ignored", m_cfg, mkcfg(0, 3'd6, 1));

    // short read: next result replaces unread bits (R3)
    do_conv('0, 0, 5);
    do_conv('0, 0, 28);

    // rising cnv mid-conversion ignored (R1)
    cnv_i = 1'b1; tick();
    repeat (5) tick();
    cnv_i = 1'b0; tick();
    chk("R1 no early enable", sdo_oe_o, 0);
    cnv_i = 1'b1; tick();
    repeat (C - 7) tick();
    model_eoc();
    cnv_i = 1'b0; tick();
    chk("R1 eoc on time", sdo_oe_o, 1);
    do_read('0, 0, 28, "R1 R10 result");
    do_conv('0, 0, 28);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule